// File: doc/BRIEF.md
# Ethernet 10/100 Transmit Framer

This block forms the transmit side of a 10/100 Ethernet MAC. An upstream source hands it frame bytes, destination address first, over a byte stream with valid, last and ready signals. The block sends each frame to the PHY in order: a preamble, a start-of-frame delimiter, the payload and a CRC-32 frame check sequence (FCS). It drives either 4-bit MII nibbles or 2-bit RMII dibits.

The block runs on the PHY-side clock. In MII mode that clock is the transmit clock of the PHY, at 25 MHz or 2.5 MHz, so the block sends one nibble per clock at either speed. In RMII mode it is the 50 MHz reference. At 100 Mb/s one dibit goes out per clock. At 10 Mb/s each dibit is held for ten clocks.

The block never drives the PHY transmit-error pin. If the source runs dry in the middle of a frame, the block closes the frame after the byte it is sending and sends the FCS with every bit inverted, so that receivers on the network discard the frame. Mode and speed are sampled while reset is held. After reset they are frozen.

Top module: `eth_tx_framer`

## Requirements
- R1: While `rst_n` is low and on the cycle after it goes high, `tx_en`=0, `txd`=0, `tx_er`=0 and `s_ready`=1.
- R2: Every frame starts with seven bytes of 0x55 and then one byte of 0xD5. Each byte goes out low nibble first (MII) or lowest dibit first (RMII). In MII the first symbol seen with `tx_en` high is 4'h5, and in RMII it is 2'b01. The first payload byte is accepted from idle. The second is accepted nine byte times later.
- R3: A byte moves on a rising edge with `s_valid` and `s_ready` both high. Payload bytes go out in the order they were accepted, each sent in full. A frame may be a single byte long.
- R4: The FCS is the reflected CRC-32, with polynomial 0x04C11DB7 and initial value 0xFFFFFFFF, taken over all payload bytes. It is complemented and sent least-significant byte first, right after the last payload byte.
- R5: An underflow occurs when `s_valid` is low at a point where `s_ready` is high within a frame whose last byte has not yet been seen. The frame then ends after the byte in flight, and its four FCS bytes are the bitwise inverse of the correct FCS.
- R6: `tx_er` is never high.
- R7: With `cfg_rmii`=0 (MII), data leaves on `txd[3:0]` at one nibble per clock, whatever the value of `cfg_fast`.
- R8: With `cfg_rmii`=1 (RMII), data leaves on `txd[1:0]` and `txd[3:2]` is 0. With `cfg_fast`=1 one dibit goes out per clock. With `cfg_fast`=0 each dibit is held for ten clocks.
- R9: `tx_en` rises with the first preamble symbol and stays high without a gap. It falls on the clock right after the last FCS symbol.
- R10: After `tx_en` falls, `s_ready` stays low for 12 byte times: 24 clocks in MII, 48 in RMII at 100 Mb/s and 480 in RMII at 10 Mb/s.
- R11: `cfg_rmii` and `cfg_fast` take effect only while `rst_n` is low. A change while out of reset has no effect on the frames that follow.
- R12: Inside a frame, `s_ready` is high only on the last clock of each payload byte, so back-to-back bytes are accepted one byte time apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PHY-side clock (MII transmit clock or RMII reference) |
| rst_n | input | 1 | Synchronous active-low reset; mode inputs are sampled while low |
| cfg_rmii | input | 1 | 1 = RMII dibits, 0 = MII nibbles |
| cfg_fast | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s (matters in RMII only) |
| s_data | input | 8 | Frame byte from the source |
| s_valid | input | 1 | `s_data` holds a byte |
| s_last | input | 1 | This byte ends the frame |
| s_ready | output | 1 | The block takes the byte on this edge |
| tx_en | output | 1 | Transmit enable to the PHY |
| txd | output | 4 | Transmit data: nibble in MII, dibit on bits 1:0 in RMII |
| tx_er | output | 1 | Transmit coding error, always low |

## Verification
Assertions check the following on every cycle:
- The first symbol of each frame carries the preamble pattern.
- Accepting a byte from idle starts a frame.
- `tx_en` falls only out of the FCS phase, and `s_ready` is then low.
- Dibits stay stable through each ten-clock hold at 10 Mb/s RMII.
- The latched mode never changes after reset.

Only the scoreboard scenarios can show the rest:
- The FCS values are correct, including the inverted FCS after an underflow.
- Payload order is kept and the frame length is exact.
- The inter-packet gap and the spacing between accepted bytes are right.
- A mode change outside reset is ignored.

// File: rtl/eth_tx_framer.sv
`timescale 1ns/1ps
module eth_tx_framer #(
  parameter int PRE_BYTES = 7,
  parameter int IPG_BYTES = 12,
  parameter int SLOW_HOLD = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_rmii,
  input  logic       cfg_fast,
  input  logic [7:0] s_data,
  input  logic       s_valid,
  input  logic       s_last,
  output logic       s_ready,
  output logic       tx_en,
  output logic [3:0] txd,
  output logic       tx_er
);

  localparam int CMAX = (PRE_BYTES + 1 > IPG_BYTES) ? PRE_BYTES + 1 : IPG_BYTES;
  localparam int CW = $clog2(CMAX + 1);
  localparam int HW = $clog2(SLOW_HOLD + 1);
  localparam logic [CW-1:0] SFD_IDX = CW'(PRE_BYTES);
  localparam logic [CW-1:0] PRE_IDX = CW'(PRE_BYTES - 1);
  localparam logic [CW-1:0] IPG_IDX = CW'(IPG_BYTES - 1);
  localparam logic [CW-1:0] FCS_IDX = CW'(3);

  typedef enum logic [2:0] {ST_IDLE, ST_PRE, ST_DATA, ST_FCS, ST_IPG} st_t;

  st_t            state;
  logic           mode_rmii, mode_fast;
  logic [HW-1:0]  hold_cnt;
  logic [1:0]     sym_cnt;
  logic [CW-1:0]  byte_cnt;
  logic [31:0]    sh, crc;
  logic [7:0]     first;
  logic           cur_last;

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'b0, d};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  wire slow     = mode_rmii && !mode_fast;
  wire tick     = hold_cnt == (slow ? HW'(SLOW_HOLD - 1) : '0);
  wire byte_end = tick && (sym_cnt == (mode_rmii ? 2'd3 : 2'd1));

  assign s_ready = (state == ST_IDLE) || (state == ST_DATA && byte_end && !cur_last);
  assign tx_en   = (state == ST_PRE) || (state == ST_DATA) || (state == ST_FCS);
  assign txd     = !tx_en ? 4'h0 : mode_rmii ? {2'b00, sh[1:0]} : sh[3:0];
  assign tx_er   = 1'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      mode_rmii <= cfg_rmii;
      mode_fast <= cfg_fast;
      hold_cnt  <= '0;
      sym_cnt   <= '0;
      byte_cnt  <= '0;
      sh        <= '0;
      crc       <= '1;
      first     <= '0;
      cur_last  <= 1'b0;
    end else begin
      if (state != ST_IDLE) begin
        if (tick) begin
          hold_cnt <= '0;
          sym_cnt  <= byte_end ? 2'd0 : sym_cnt + 2'd1;
          sh       <= mode_rmii ? (sh >> 2) : (sh >> 4);
        end else begin
          hold_cnt <= hold_cnt + 1'b1;
        end
      end
      case (state)
        ST_IDLE: if (s_valid) begin
          first    <= s_data;
          cur_last <= s_last;
          crc      <= crc_byte('1, s_data);
          sh       <= 32'h55;
          byte_cnt <= '0;
          hold_cnt <= '0;
          sym_cnt  <= '0;
          state    <= ST_PRE;
        end
        ST_PRE: if (byte_end) begin
          byte_cnt <= byte_cnt + 1'b1;
          if (byte_cnt == SFD_IDX) begin
            sh    <= {24'b0, first};
            state <= ST_DATA;
          end else if (byte_cnt == PRE_IDX) sh <= 32'hD5;
          else sh <= 32'h55;
        end
        ST_DATA: if (byte_end) begin
          if (cur_last) begin
            sh       <= ~crc;
            byte_cnt <= '0;
            state    <= ST_FCS;
          end else if (s_valid) begin
            sh       <= {24'b0, s_data};
            cur_last <= s_last;
            crc      <= crc_byte(crc, s_data);
          end else begin
            sh       <= crc;
            byte_cnt <= '0;
            state    <= ST_FCS;
          end
        end
        ST_FCS: if (byte_end) begin
          byte_cnt <= byte_cnt + 1'b1;
          if (byte_cnt == FCS_IDX) begin
            byte_cnt <= '0;
            state    <= ST_IPG;
          end
        end
        ST_IPG: if (byte_end) begin
          byte_cnt <= byte_cnt + 1'b1;
          if (byte_cnt == IPG_IDX) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_accept_starts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && s_valid) |=> (tx_en && !s_ready));

  p_preamble_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !$past(tx_en)) |-> (txd == (mode_rmii ? 4'h1 : 4'h5)));

  p_end_after_fcs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_en) |-> ($past(state == ST_FCS) && !s_ready));

  p_dibit_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (slow && tx_en && $past(tx_en) && hold_cnt != '0) |-> $stable(txd));

  p_mode_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ($stable(mode_rmii) && $stable(mode_fast)));

endmodule

// File: tb/test_eth_tx_framer.sv
`timescale 1ns/1ps
module test_eth_tx_framer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_rmii = 1'b0, cfg_fast = 1'b0;
  logic [7:0] s_data = '0;
  logic s_valid = 1'b0, s_last = 1'b0;
  logic s_ready, tx_en, tx_er;
  logic [3:0] txd;

  eth_tx_framer i_eth_tx_framer (
    .clk(clk), .rst_n(rst_n), .cfg_rmii(cfg_rmii), .cfg_fast(cfg_fast),
    .s_data(s_data), .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready),
    .tx_en(tx_en), .txd(txd), .tx_er(tx_er));

  always #2.5 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  logic [3:0] exp_q[$];
  logic [3:0] e;
  logic prev_en = 1'b0, er_seen = 1'b0;
  string req_tag = "R2";
  bit exp_rmii, exp_fast;
  logic [7:0] pl[64];
  int acc[64];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", req, what, act, expv, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (tx_er) er_seen = 1'b1;
    if (tx_en) begin
      if (exp_q.size() == 0) check(0, req_tag, "unexpected symbol", int'(txd), 0);
      else begin
        e = exp_q.pop_front();
        check(txd == e, req_tag, "symbol", int'(txd), int'(e));
      end
    end
    if (prev_en && !tx_en) check(exp_q.size() == 0, "R9", "symbols left at tx_en fall", exp_q.size(), 0);
    prev_en = tx_en;
  end

  function automatic int syms(); return exp_rmii ? 4 : 2; endfunction
  function automatic int hold(); return (exp_rmii && !exp_fast) ? 10 : 1; endfunction

  task automatic push_byte(input logic [7:0] b);
    for (int k = 0; k < syms(); k++) begin
      logic [3:0] s;
      s = exp_rmii ? {2'b00, 2'(b >> (2 * k))} : 4'(b >> (4 * k));
      repeat (hold()) exp_q.push_back(s);
    end
  endtask

  function automatic logic [31:0] model_crc(input int n);
    logic [31:0] c;
    logic fb;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++) begin
        fb = c[0] ^ pl[i][b];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    return c;
  endfunction

  task automatic do_reset(input bit rm, input bit fa);
    rst_n = 1'b0;
    cfg_rmii = rm;
    cfg_fast = fa;
    exp_rmii = rm;
    exp_fast = fa;
    repeat (3) @(negedge clk);
    check(!tx_en && txd == 0 && !tx_er && s_ready, "R1", "outputs during reset", {tx_en, txd, tx_er, s_ready}, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(!tx_en && txd == 0 && !tx_er && s_ready, "R1", "outputs after reset", {tx_en, txd, tx_er, s_ready}, 1);
  endtask

  task automatic send_frame(input int n, input bit under, input int seed, input string tag);
    logic [31:0] c;
    int cnt;
    req_tag = tag;
    for (int i = 0; i < n; i++) pl[i] = 8'(i * 37 + seed);
    for (int i = 0; i < 7; i++) push_byte(8'h55);
    push_byte(8'hD5);
    for (int i = 0; i < n; i++) push_byte(pl[i]);
    c = model_crc(n);
    if (!under) c = ~c;
    for (int i = 0; i < 4; i++) push_byte(c[8*i +: 8]);
    for (int i = 0; i < n; i++) begin
      s_valid = 1'b1;
      s_data = pl[i];
      s_last = !under && (i == n - 1);
      while (!s_ready) @(negedge clk);
      @(negedge clk);
      acc[i] = cyc;
    end
    s_valid = 1'b0;
    s_last = 1'b0;
    if (!under && n >= 3) begin
      check(acc[1] - acc[0] == 9 * syms() * hold(), "R2", "preamble+first byte span", acc[1] - acc[0], 9 * syms() * hold());
      check(acc[2] - acc[1] == syms() * hold(), "R12", "byte accept spacing", acc[2] - acc[1], syms() * hold());
    end
    while (tx_en) @(negedge clk);
    cnt = 0;
    while (!s_ready) begin
      cnt++;
      @(negedge clk);
    end
    check(cnt == 12 * syms() * hold(), "R10", "inter-packet gap", cnt, 12 * syms() * hold());
    check(exp_q.size() == 0, "R9", "frame fully sent", exp_q.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog expired act=%0d exp=%0d", cyc, 200000);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset(1'b0, 1'b0);
    send_frame(20, 1'b0, 3, "R2 R3 R4 R7");
    send_frame(1, 1'b0, 91, "R3 R4");
    do_reset(1'b0, 1'b1);
    send_frame(5, 1'b0, 17, "R7 R4");
    send_frame(6, 1'b1, 44, "R5");
    do_reset(1'b1, 1'b1);
    send_frame(16, 1'b0, 5, "R8 R4");
    send_frame(3, 1'b1, 120, "R5 R8");
    do_reset(1'b1, 1'b0);
    send_frame(4, 1'b0, 77, "R8");
    do_reset(1'b0, 1'b0);
    cfg_rmii = 1'b1;
    cfg_fast = 1'b1;
    send_frame(8, 1'b0, 9, "R11");
    check(!er_seen, "R6", "tx_er seen high", int'(er_seen), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule